// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level translation table that sits in ordinary memory. A caller presents a translate request with the virtual address and an access kind (instruction fetch, data load or data store). The caller also supplies the page number of the first-level table, which is the only fixed location in the whole structure. The walker then issues one memory read for the first-level entry and a second read for the leaf entry. Each read holds its request until the memory returns a response-valid pulse.

The virtual address has three fields. The top 10 bits pick the first-level entry, the next 10 bits pick the leaf entry, and the low 12 bits are the byte offset inside a 4 KB page. A clear valid bit at either level ends the walk with a page fault. A leaf whose permission bits forbid the access ends the walk with a protection fault. A permitted access produces the leaf's page number joined to the unchanged offset, and the leaf's cache-disable flag is reported alongside it. A permitted access also marks the leaf as referenced, and a store additionally marks it as modified. The leaf is written back to memory only when one of these two status bits actually changes.

Entry layout, used at both levels:
- Bits 31..12 hold the page number.
- Bit 0 is valid.
- Bit 1 is readable.
- Bit 2 is writable.
- Bit 3 is executable.
- Bit 4 is referenced.
- Bit 5 is modified.
- Bit 6 is cache-disable.
- Bits 11..7 are unused.

Access kind codes:
- 0 is fetch.
- 1 is load.
- 2 is store.
- 3 is handled exactly like a load.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and done, mem_req, page_fault, prot_fault, uncached and paddr are all 0.
- R2: The first read goes to byte address dir_base*4096 + vaddr[31:22]*4. The second read goes to leaf_table_page*4096 + vaddr[21:12]*4, where leaf_table_page is bits 31..12 of the first-level entry.
- R3: A first-level entry with bit 0 clear ends the walk after that single read. The walk reports page_fault=1, prot_fault=0 and paddr=0, and performs no memory write.
- R4: A leaf entry with bit 0 clear gives page_fault=1 and paddr=0 after exactly two reads, with no memory write.
- R5: A permitted access gives paddr = {leaf bits 31..12, vaddr[11:0]}, and uncached equals leaf bit 6, with both fault flags at 0.
- R6: A permitted access of any kind writes the leaf back with bit 4 (referenced) set, and leaves all other bits as they were except bit 5 on a store.
- R7: Only a store (code 2) sets bit 5 (modified). A fetch or a load leaves bit 5 unchanged.
- R8: When the leaf already has every status bit the access would set, no memory write happens.
- R9: A store to a leaf with bit 2 clear, a fetch from a leaf with bit 3 clear, or a load (code 1 or 3) from a leaf with bit 1 clear each give prot_fault=1 and page_fault=0. Such a walk reports paddr=0 and leaves the leaf unmodified in memory.
- R10: While a read gets no response, mem_req stays at 1 with mem_we at 0 and mem_addr unchanged. Walks complete correctly for any response latency.
- R11: done is high for exactly one cycle per walk, after which req_ready returns to 1. req_ready is 0 during a walk, and a req_valid seen while req_ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translate request, taken when req_ready is 1 |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 as load |
| dir_base | input | 20 | Page number of the first-level table, captured with the request |
| mem_req | output | 1 | Memory access request (held until response for reads) |
| mem_we | output | 1 | Memory access is a one-cycle write of mem_wdata |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Updated leaf entry for write-back |
| mem_rvalid | input | 1 | One-cycle read response strobe |
| mem_rdata | input | 32 | Read response data |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| paddr | output | 32 | Physical address, 0 on any fault |
| uncached | output | 1 | Cache-disable flag of the leaf, 0 on any fault |
| page_fault | output | 1 | A valid bit was clear at some level |
| prot_fault | output | 1 | Permission bits deny the access kind |

## Verification
The hardest situation to reach from the ports is a walk that has been slowed by memory, combined with a second translate request arriving mid-walk. Under that stress, the read address must stay frozen and the stray request must neither disturb the result nor start a second walk. To get there, the bench memory model has a per-walk response latency knob, which is set high so the walker sits in its first read for several cycles. The bench then pulses req_valid with a different address and checks the held address, the first request's result, and the read count afterwards. A second hard case is telling a needed write-back apart from a redundant one. The bench reaches it by touching the same leaf repeatedly with different access kinds and counting writes at the memory port.

// File: rtl/pw_pkg.sv
// Package pw_pkg
// Shared constants and types for the two-level page table walker.
// Assumes: one entry layout at both levels, flags in the low bits,
// page number in the top bits of a 32-bit entry.
package pw_pkg;

    localparam int PW_VA_W  = 32;   // virtual and physical address width
    localparam int PW_OFF_W = 12;   // page offset width (4 KB pages)
    localparam int PW_IDX_W = 10;   // index width per table level
    localparam int PW_ENT_W = 32;   // table entry width

    // Entry flag positions
    localparam int F_VALID = 0;
    localparam int F_RD    = 1;
    localparam int F_WR    = 2;
    localparam int F_EX    = 3;
    localparam int F_REF   = 4;
    localparam int F_MOD   = 5;
    localparam int F_NC    = 6;

    // Access kind codes on req_kind
    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_LOAD  = 2'd1;
    localparam logic [1:0] KIND_STORE = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DIR  = 3'd1,
        ST_LEAF = 3'd2,
        ST_WB   = 3'd3,
        ST_DONE = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_PAGE = 2'd1,
        RES_PROT = 2'd2
    } walk_result_e;

endpackage

// File: rtl/pw_entry_addr.sv
// Module pw_entry_addr
// Forms the byte address of a table entry: the table's page number
// followed by the index scaled to 4-byte entries.
// Assumes: IDX_W + 2 <= OFF_W, so the index fits inside one page.
module pw_entry_addr #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic [VA_W-OFF_W-1:0] tbl_page,
    input  logic [IDX_W-1:0]      ent_idx,
    output logic [VA_W-1:0]       ent_addr
);

    logic [OFF_W-1:0] byte_off;

    // Scale the entry index to a byte offset inside the table page
    always_comb begin
        byte_off = '0;
        byte_off[IDX_W+1:2] = ent_idx;
    end

    // Join page number and in-page offset
    assign ent_addr = {tbl_page, byte_off};

endmodule

// File: rtl/pw_leaf_eval.sv
// Module pw_leaf_eval
// Judges a leaf entry against the access kind: page fault on clear
// valid, protection fault on missing permission, otherwise computes the
// entry with referenced (and, for stores, modified) set and whether it
// differs from the stored entry.
// Assumes: kind code 3 is treated like a load.
module pw_leaf_eval
    import pw_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] leaf,
    input  logic [1:0]       kind,
    output walk_result_e     verdict,
    output logic [ENT_W-1:0] leaf_next,
    output logic             leaf_dirty
);

    logic denied;

    // Pick the permission bit the access kind needs
    always_comb begin
        unique case (kind)
            KIND_FETCH: denied = !leaf[F_EX];
            KIND_STORE: denied = !leaf[F_WR];
            default:    denied = !leaf[F_RD];
        endcase
    end

    // Decide the outcome and the updated status bits
    always_comb begin
        verdict   = RES_OK;
        leaf_next = leaf;
        if (!leaf[F_VALID]) begin
            verdict = RES_PAGE;
        end else if (denied) begin
            verdict = RES_PROT;
        end else begin
            leaf_next[F_REF] = 1'b1;
            if (kind == KIND_STORE) begin
                leaf_next[F_MOD] = 1'b1;
            end
        end
    end

    // Write-back is needed only when a status bit actually changes
    assign leaf_dirty = (verdict == RES_OK) && (leaf_next != leaf);

endmodule

// File: rtl/pw_walk_seq.sv
// Module pw_walk_seq
// Sequencer for the walk: idle, first-level read, leaf read, optional
// leaf write-back, one-cycle done. Captures the request, the table page
// numbers and the results.
// Assumes: a read response arrives as a single-cycle mem_rvalid while
// the read is requested; a write completes in the cycle it is issued.
module pw_walk_seq
    import pw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int ENT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_kind,
    input  logic [VA_W-OFF_W-1:0] dir_base,
    input  logic                  mem_rvalid,
    input  logic [ENT_W-1:0]      mem_rdata,
    input  walk_result_e          verdict,
    input  logic [ENT_W-1:0]      leaf_next,
    input  logic                  leaf_dirty,
    output walk_state_e           state,
    output logic [VA_W-1:0]       vaddr_q,
    output logic [1:0]            kind_q,
    output logic [VA_W-OFF_W-1:0] base_q,
    output logic [VA_W-OFF_W-1:0] tbl_page_q,
    output logic [ENT_W-1:0]      wb_data_q,
    output logic [VA_W-1:0]       paddr_q,
    output logic                  nc_q,
    output logic                  pf_q,
    output logic                  prot_q
);

    localparam int PPN_W = VA_W - OFF_W;

    logic [PPN_W-1:0] rd_page;

    // Page number field of the entry just returned
    assign rd_page = mem_rdata[ENT_W-1 -: PPN_W];

    // Walk state machine and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            vaddr_q    <= '0;
            kind_q     <= '0;
            base_q     <= '0;
            tbl_page_q <= '0;
            wb_data_q  <= '0;
            paddr_q    <= '0;
            nc_q       <= 1'b0;
            pf_q       <= 1'b0;
            prot_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        kind_q  <= req_kind;
                        base_q  <= dir_base;
                        state   <= ST_DIR;
                    end
                end
                ST_DIR: begin
                    if (mem_rvalid) begin
                        if (!mem_rdata[F_VALID]) begin
                            pf_q    <= 1'b1;
                            prot_q  <= 1'b0;
                            paddr_q <= '0;
                            nc_q    <= 1'b0;
                            state   <= ST_DONE;
                        end else begin
                            tbl_page_q <= rd_page;
                            state      <= ST_LEAF;
                        end
                    end
                end
                ST_LEAF: begin
                    if (mem_rvalid) begin
                        pf_q      <= (verdict == RES_PAGE);
                        prot_q    <= (verdict == RES_PROT);
                        wb_data_q <= leaf_next;
                        if (verdict == RES_OK) begin
                            paddr_q <= {rd_page, vaddr_q[OFF_W-1:0]};
                            nc_q    <= mem_rdata[F_NC];
                        end else begin
                            paddr_q <= '0;
                            nc_q    <= 1'b0;
                        end
                        state <= leaf_dirty ? ST_WB : ST_DONE;
                    end
                end
                ST_WB:   state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pt_walker.sv
// Module pt_walker (top)
// Two-level page table walker: translates a virtual address through a
// first-level and a leaf table in memory, reports page and protection
// faults, and writes back referenced/modified status on the leaf.
// Assumes: VA_W == OFF_W + 2*IDX_W; memory is byte addressed with
// 4-byte entries; dir_base is the page number of the first-level table.
module pt_walker
    import pw_pkg::*;
#(
    parameter int VA_W  = PW_VA_W,
    parameter int OFF_W = PW_OFF_W,
    parameter int IDX_W = PW_IDX_W,
    parameter int ENT_W = PW_ENT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_kind,
    input  logic [VA_W-OFF_W-1:0] dir_base,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [VA_W-1:0]       mem_addr,
    output logic [ENT_W-1:0]      mem_wdata,
    input  logic                  mem_rvalid,
    input  logic [ENT_W-1:0]      mem_rdata,
    output logic                  done,
    output logic [VA_W-1:0]       paddr,
    output logic                  uncached,
    output logic                  page_fault,
    output logic                  prot_fault
);

    localparam int PPN_W  = VA_W - OFF_W;
    localparam int LEVELS = 2;

    walk_state_e      state;
    logic [VA_W-1:0]  vaddr_q;
    logic [1:0]       kind_q;
    logic [PPN_W-1:0] base_q;
    logic [PPN_W-1:0] tbl_page_q;
    logic [ENT_W-1:0] wb_data_q;
    walk_result_e     verdict;
    logic [ENT_W-1:0] leaf_next;
    logic             leaf_dirty;

    logic [PPN_W-1:0] lvl_page [LEVELS];
    logic [IDX_W-1:0] lvl_idx  [LEVELS];
    logic [VA_W-1:0]  lvl_addr [LEVELS];

    // Level 0 indexes the first-level table, level 1 the leaf table
    assign lvl_page[0] = base_q;
    assign lvl_idx[0]  = vaddr_q[VA_W-1 -: IDX_W];
    assign lvl_page[1] = tbl_page_q;
    assign lvl_idx[1]  = vaddr_q[OFF_W+IDX_W-1 -: IDX_W];

    // One entry address generator per table level
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        pw_entry_addr #(
            .VA_W  (VA_W),
            .OFF_W (OFF_W),
            .IDX_W (IDX_W)
        ) u_addr (
            .tbl_page (lvl_page[lv]),
            .ent_idx  (lvl_idx[lv]),
            .ent_addr (lvl_addr[lv])
        );
    end

    pw_leaf_eval #(
        .ENT_W (ENT_W)
    ) u_eval (
        .leaf       (mem_rdata),
        .kind       (kind_q),
        .verdict    (verdict),
        .leaf_next  (leaf_next),
        .leaf_dirty (leaf_dirty)
    );

    pw_walk_seq #(
        .VA_W  (VA_W),
        .OFF_W (OFF_W),
        .ENT_W (ENT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_kind   (req_kind),
        .dir_base   (dir_base),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .verdict    (verdict),
        .leaf_next  (leaf_next),
        .leaf_dirty (leaf_dirty),
        .state      (state),
        .vaddr_q    (vaddr_q),
        .kind_q     (kind_q),
        .base_q     (base_q),
        .tbl_page_q (tbl_page_q),
        .wb_data_q  (wb_data_q),
        .paddr_q    (paddr),
        .nc_q       (uncached),
        .pf_q       (page_fault),
        .prot_q     (prot_fault)
    );

    // Memory port drive from the walk state
    always_comb begin
        mem_req  = (state == ST_DIR) || (state == ST_LEAF) || (state == ST_WB);
        mem_we   = (state == ST_WB);
        mem_addr = (state == ST_DIR) ? lvl_addr[0] : lvl_addr[1];
    end

    assign mem_wdata = wb_data_q;
    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/pt_walker_chk.sv
// Module pt_walker_chk
// Assertion checker for pt_walker, attached by bind. Observes only the
// top-level ports.
module pt_walker_chk
    import pw_pkg::*;
#(
    parameter int VA_W  = PW_VA_W,
    parameter int ENT_W = PW_ENT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [VA_W-1:0]  mem_addr,
    input logic [ENT_W-1:0] mem_wdata,
    input logic             mem_rvalid,
    input logic             done,
    input logic [VA_W-1:0]  paddr,
    input logic             uncached,
    input logic             page_fault,
    input logic             prot_fault
);

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_rvalid) |=> (mem_req && !mem_we && $stable(mem_addr)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !req_ready));

    // R9
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(page_fault && prot_fault));

    // R3
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (page_fault || prot_fault)) |-> (paddr == '0 && !uncached));

    // R6
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[F_REF] && mem_wdata[F_VALID]));

    // R6
    wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (done && !mem_req));

endmodule

bind pt_walker pt_walker_chk #(
    .VA_W  (VA_W),
    .ENT_W (ENT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .paddr      (paddr),
    .uncached   (uncached),
    .page_fault (page_fault),
    .prot_fault (prot_fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
// Directed bench for pt_walker with a latency-controlled memory model.
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [19:0] dir_base = 20'd1;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done;
    logic [31:0] paddr;
    logic        uncached, page_fault, prot_fault;

    always #2.5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .dir_base(dir_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .paddr(paddr), .uncached(uncached),
        .page_fault(page_fault), .prot_fault(prot_fault)
    );

    // Memory model: 4096 words covering pages 0..3
    logic [31:0] mem [4096];
    int          lat_cfg = 0;
    int          cnt;
    logic        poke_en = 1'b0;
    logic [11:0] poke_idx = '0;
    logic [31:0] poke_data = '0;
    int          rd_n, wr_n;
    logic [31:0] rd_prev, rd_last, wr_addr, wr_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= '0;
            mem_rvalid <= 1'b0; mem_rdata <= '0; cnt <= 0;
            rd_n <= 0; wr_n <= 0; rd_prev <= '0; rd_last <= '0;
            wr_addr <= '0; wr_data <= '0;
        end else begin
            if (poke_en) mem[poke_idx] <= poke_data;
            if (mem_req && mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_n <= wr_n + 1; wr_addr <= mem_addr; wr_data <= mem_wdata;
            end
            if (mem_rvalid) begin
                mem_rvalid <= 1'b0; cnt <= 0;
            end else if (mem_req && !mem_we) begin
                if (cnt >= lat_cfg) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mem_addr[13:2]];
                    rd_n <= rd_n + 1; rd_prev <= rd_last; rd_last <= mem_addr;
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end

    int total = 0;
    int bad = 0;
    logic timed_out = 1'b0;

    // Walk results captured by do_walk
    logic [31:0] r_paddr;
    logic        r_nc, r_pf, r_prot;
    int          d_rd, d_wr;

    localparam logic [31:0] V = 32'h01, RD = 32'h02, WR = 32'h04, EX = 32'h08;
    localparam logic [31:0] REF = 32'h10, MOD = 32'h20, NC = 32'h40;

    function automatic logic [31:0] ent(input logic [19:0] pg, input logic [31:0] fl);
        return {pg, 12'h000} | fl;
    endfunction

    function automatic logic [31:0] va(input int d, input int t, input int off);
        return (32'(d) << 22) | (32'(t) << 12) | 32'(off & 12'hFFF);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] data);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 12'(idx); poke_data = data;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_dir(input int d, input logic [31:0] e);
        poke(1024 + d, e);
    endtask

    task automatic set_tbl(input int pg, input int t, input logic [31:0] e);
        poke(pg * 1024 + t, e);
    endtask

    task automatic do_walk(input logic [31:0] a, input logic [1:0] k, input int lat);
        int rd0, wr0, guard;
        lat_cfg = lat;
        @(negedge clk);
        rd0 = rd_n; wr0 = wr_n;
        req_valid = 1'b1; req_vaddr = a; req_kind = k;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        r_paddr = paddr; r_nc = uncached; r_pf = page_fault; r_prot = prot_fault;
        d_rd = rd_n - rd0; d_wr = wr_n - wr0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 done", 32'(done), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 faults", {30'd0, page_fault, prot_fault}, 32'd0);
        check("R1 paddr", paddr, 32'd0);
        check("R1 uncached", 32'(uncached), 32'd0);
    endtask

    task automatic t_load_basic;
        set_dir(5, ent(20'd2, V));
        set_tbl(2, 7, ent(20'hABCDE, V | RD | WR | EX));
        do_walk(va(5, 7, 12'h345), 2'd1, 2);
        check("R2 dir addr", rd_prev, 32'h0000_1014);
        check("R2 leaf addr", rd_last, 32'h0000_201C);
        check("R5 paddr", r_paddr, 32'hABCD_E345);
        check("R5 faults", {30'd0, r_pf, r_prot}, 32'd0);
        check("R5 uncached", 32'(r_nc), 32'd0);
        check("R6 write count", 32'(d_wr), 32'd1);
        check("R6 write addr", wr_addr, 32'h0000_201C);
        check("R7 load sets ref only", mem[2048 + 7], ent(20'hABCDE, V | RD | WR | EX | REF));
    endtask

    task automatic t_store_mod;
        do_walk(va(5, 7, 12'h008), 2'd2, 1);
        check("R7 store paddr", r_paddr, 32'hABCD_E008);
        check("R7 store write count", 32'(d_wr), 32'd1);
        check("R7 store sets mod", mem[2048 + 7], ent(20'hABCDE, V | RD | WR | EX | REF | MOD));
    endtask

    task automatic t_no_change;
        do_walk(va(5, 7, 12'hFF0), 2'd1, 3);
        check("R8 load no write", 32'(d_wr), 32'd0);
        check("R8 load paddr", r_paddr, 32'hABCD_EFF0);
        do_walk(va(5, 7, 12'h001), 2'd2, 0);
        check("R8 store no write", 32'(d_wr), 32'd0);
        check("R8 entry unchanged", mem[2048 + 7], ent(20'hABCDE, V | RD | WR | EX | REF | MOD));
    endtask

    task automatic t_dir_invalid;
        set_dir(9, ent(20'd3, RD | WR | EX));
        do_walk(va(9, 0, 12'h010), 2'd1, 1);
        check("R3 page fault", {30'd0, r_pf, r_prot}, 32'd2);
        check("R3 paddr", r_paddr, 32'd0);
        check("R3 single read", 32'(d_rd), 32'd1);
        check("R3 no write", 32'(d_wr), 32'd0);
        check("R3 dir addr", rd_last, 32'h0000_1024);
    endtask

    task automatic t_leaf_invalid;
        set_dir(6, ent(20'd3, V));
        set_tbl(3, 0, ent(20'h55555, RD | WR | EX));
        do_walk(va(6, 0, 12'h0AB), 2'd0, 2);
        check("R4 page fault", {30'd0, r_pf, r_prot}, 32'd2);
        check("R4 paddr", r_paddr, 32'd0);
        check("R4 two reads", 32'(d_rd), 32'd2);
        check("R4 no write", 32'(d_wr), 32'd0);
        check("R2 leaf addr page 3", rd_last, 32'h0000_3000);
    endtask

    task automatic t_protection;
        set_tbl(3, 1, ent(20'h12345, V | RD));
        do_walk(va(6, 1, 12'h004), 2'd2, 1);
        check("R9 store no W", {30'd0, r_pf, r_prot}, 32'd1);
        check("R9 store paddr", r_paddr, 32'd0);
        check("R9 store no write", 32'(d_wr), 32'd0);
        do_walk(va(6, 1, 12'h004), 2'd0, 1);
        check("R9 fetch no X", {30'd0, r_pf, r_prot}, 32'd1);
        check("R9 leaf untouched", mem[3072 + 1], ent(20'h12345, V | RD));
        do_walk(va(6, 1, 12'h204), 2'd3, 1);
        check("R9 code3 as load ok", r_paddr, 32'h1234_5204);
        check("R9 code3 no mod", mem[3072 + 1], ent(20'h12345, V | RD | REF));
        set_tbl(3, 2, ent(20'h2468A, V | WR | EX));
        do_walk(va(6, 2, 12'h100), 2'd1, 0);
        check("R9 load no R", {30'd0, r_pf, r_prot}, 32'd1);
        check("R9 load no R write", 32'(d_wr), 32'd0);
        do_walk(va(6, 2, 12'h100), 2'd2, 0);
        check("R9 store allowed", r_paddr, 32'h2468_A100);
        check("R7 store ref+mod", mem[3072 + 2], ent(20'h2468A, V | WR | EX | REF | MOD));
    endtask

    task automatic t_uncached;
        set_tbl(3, 3, ent(20'h00FFF, V | EX | NC));
        do_walk(va(6, 3, 12'hFFF), 2'd0, 0);
        check("R5 uncached paddr", r_paddr, 32'h00FF_FFFF);
        check("R5 uncached flag", 32'(r_nc), 32'd1);
        check("R6 fetch sets ref", mem[3072 + 3], ent(20'h00FFF, V | EX | NC | REF));
        check("R7 fetch no mod", 32'(mem[3072 + 3] & MOD), 32'd0);
    endtask

    task automatic t_busy_slow;
        int rd0, guard;
        logic [31:0] held;
        lat_cfg = 6;
        @(negedge clk);
        rd0 = rd_n;
        req_valid = 1'b1; req_vaddr = va(5, 7, 12'h111); req_kind = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 busy not ready", 32'(req_ready), 32'd0);
        held = mem_addr;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va(9, 4, 12'h222); req_kind = 2'd2;
        check("R10 req held", 32'(mem_req), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 addr held", mem_addr, held);
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check("R10 slow paddr", paddr, 32'hABCD_E111);
        @(negedge clk);
        check("R11 done one cycle", 32'(done), 32'd0);
        check("R11 ready after", 32'(req_ready), 32'd1);
        @(negedge clk);
        check("R11 stray ignored", 32'(mem_req), 32'd0);
        check("R11 read count", 32'(rd_n - rd0), 32'd2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_load_basic();
                t_store_mod();
                t_no_change();
                t_dir_invalid();
                t_leaf_invalid();
                t_protection();
                t_uncached();
                t_busy_slow();
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule